// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block takes an asynchronous-strobe DRAM from normal operation into its low-power self-refresh state and back. A sleep request starts a CAS-before-RAS style entry: CAS is pulled low first, RAS follows a programmable number of cycles later, and RAS is then held low for at least the self-refresh threshold before the device may be woken. A wake request ends the sleep by raising RAS, then CAS, and then holding both high for the exit precharge. After that the block hands control back to the normal refresh scheduler and raises a refresh request, so that the first normal refresh follows the wake-up promptly.

The block also enforces the guard interval between the last normal refresh and the start of self-refresh. The refresh scheduler reports its activity on two sideband pulses: one for every normal refresh cycle and one for the first cycle of a refresh burst. A two-bit strategy input chooses distributed or burst refresh, and CAS-before-RAS or RAS-only refresh. The choice selects the timing marker and the window limit. If entering straight away would break the window, the sequencer first runs one CAS-before-RAS refresh cycle of its own and then enters.

The state machine has these states. ST_IDLE is normal operation. ST_CATCH_CAS, ST_CATCH_RAS and ST_CATCH_PRE make up the catch-up refresh cycle. In ST_ENTER_CAS, CAS leads RAS. ST_SR_MIN is the enforced minimum sleep and ST_SR_HOLD is the sleep that can be woken. ST_EXIT_RAS raises RAS while CAS stays low, and ST_EXIT_PRE is the exit precharge.

The transitions are:
- ST_IDLE goes to ST_ENTER_CAS on a sleep request when the window allows it, and to ST_CATCH_CAS otherwise.
- Each timed state (CATCH_CAS, CATCH_RAS, CATCH_PRE, ENTER_CAS, SR_MIN, EXIT_RAS, EXIT_PRE) moves to the next state in that order when its phase length has run out.
- ST_SR_HOLD goes to ST_EXIT_RAS on a wake request.
- ST_EXIT_PRE returns to ST_IDLE.

Top module: `srx_seq`

## Requirements
- R1: During and right after reset, ras_n and cas_n are high, and busy, asleep and ref_req are low.
- R2: On a sleep request in idle, cas_n goes low T_CSR cycles before ras_n goes low. RAS is never low while CAS is high.
- R3: Once ras_n falls for self-refresh, asleep is high. RAS stays low for at least T_RASS cycles, and a wake request during those cycles has no effect until they have elapsed.
- R4: The strategy code is strat_i[1] = 1 for burst and strat_i[0] = 1 for RAS-only. The window limit is WIN_DIST_CBR for code 00, WIN_DIST_RO for 01, WIN_BURST for 10 and WIN_BURST - RO_EXIT_RSV for 11. The self-refresh RAS fall comes at most that many cycles after the clock edge of the latest refresh marker.
- R5: The block runs a catch-up refresh first when a direct entry would fall later than the limit, that is, when age + 1 + T_CSR exceeds the limit. The catch-up is CAS low for T_CSR cycles, then RAS and CAS low for T_CRAS cycles, then both high for T_RP cycles. Its RAS fall counts as the new marker.
- R6: In distributed modes the marker is ref_tick and burst_start is ignored. In burst modes the marker is burst_start and ref_tick is ignored.
- R7: A wake request in held sleep raises ras_n first. cas_n follows T_CHS cycles later, and both then stay high for T_RPS cycles with busy high.
- R8: ref_req rises in the cycle the block returns to idle after an exit and stays high until a ref_tick is sampled.
- R9: busy is high in every sequencing state and low in idle and in held sleep. asleep is high only while RAS is held low for self-refresh.
- R10: After reset the refresh age is treated as stale, so the first sleep request always starts with a catch-up refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strat_i | input | 2 | Refresh strategy: bit 1 burst, bit 0 RAS-only |
| sleep_req | input | 1 | Request to enter self-refresh (level) |
| wake_req | input | 1 | Request to leave self-refresh (level) |
| ref_tick | input | 1 | Pulse: a normal refresh cycle was issued |
| burst_start | input | 1 | Pulse: first cycle of a refresh burst |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| busy | output | 1 | Entry or exit sequence in progress |
| asleep | output | 1 | DRAM is in self-refresh |
| ref_req | output | 1 | Request for an immediate normal refresh after exit |

## Verification
The bench builds the block with phase lengths of a few cycles, a minimum sleep of 20 cycles and window limits of 40, 15, 90 and 30 cycles for the four strategy codes. With these values the catch-up path and the direct path of every strategy can be reached within a few dozen idle cycles, on both sides of each limit. The short minimum sleep makes an early wake that must be held off cheap to provoke. The small limits also let a stale marker of the wrong kind (a ref_tick in burst mode, a burst_start in distributed mode) be shown to be ignored.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CATCH_CAS,
        ST_CATCH_RAS,
        ST_CATCH_PRE,
        ST_ENTER_CAS,
        ST_SR_MIN,
        ST_SR_HOLD,
        ST_EXIT_RAS,
        ST_EXIT_PRE
    } srx_state_e;

    function automatic int unsigned srx_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/srx_age.sv
module srx_age #(
    parameter int unsigned AGE_MAX = 100,
    parameter int unsigned AGE_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [AGE_W-1:0] age
);
    localparam logic [AGE_W-1:0] SAT = AGE_W'(AGE_MAX);

    // Age since the last refresh marker, saturating; reset value is stale.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= SAT;
        end else if (clr) begin
            age <= '0;
        end else if (age != SAT) begin
            age <= age + AGE_W'(1);
        end
    end

    // R10
    always @(posedge clk) begin
        age_range_chk: assert (!rst_n || age <= SAT);
    end
endmodule

// File: rtl/srx_win.sv
module srx_win #(
    parameter int unsigned WIN_DIST_CBR = 6250,
    parameter int unsigned WIN_DIST_RO  = 800,
    parameter int unsigned WIN_BURST    = 820000,
    parameter int unsigned RO_EXIT_RSV  = 410000,
    parameter int unsigned LIM_W        = 20
) (
    input  logic [1:0]       strat,
    input  logic             ref_tick,
    input  logic             burst_start,
    output logic [LIM_W-1:0] lim,
    output logic             mark
);
    localparam int unsigned RO_BURST_LIM =
        (WIN_BURST > RO_EXIT_RSV) ? (WIN_BURST - RO_EXIT_RSV) : 1;

    function automatic int unsigned pick_limit(input int unsigned code);
        case (code)
            0:       return WIN_DIST_CBR;
            1:       return WIN_DIST_RO;
            2:       return WIN_BURST;
            default: return RO_BURST_LIM;
        endcase
    endfunction

    logic [LIM_W-1:0] tbl [4];

    for (genvar g = 0; g < 4; g++) begin : g_tbl
        assign tbl[g] = LIM_W'(pick_limit(g));
    end

    assign lim  = tbl[strat];
    // R6: the marker source follows the distributed/burst choice
    assign mark = strat[1] ? burst_start : ref_tick;
endmodule

// File: rtl/srx_phase.sv
module srx_phase #(
    parameter int unsigned PH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [PH_W-1:0] len,
    output logic            done
);
    logic [PH_W-1:0] cnt_q;

    assign done = (cnt_q == (len - PH_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (!done && (cnt_q != '1)) begin
            cnt_q <= cnt_q + PH_W'(1);
        end
    end
endmodule

// File: rtl/srx_seq.sv
module srx_seq
    import srx_pkg::*;
#(
    parameter int unsigned T_CSR        = 1,
    parameter int unsigned T_CRAS       = 4,
    parameter int unsigned T_RP         = 3,
    parameter int unsigned T_RASS       = 5000,
    parameter int unsigned T_CHS        = 1,
    parameter int unsigned T_RPS        = 7,
    parameter int unsigned WIN_DIST_CBR = 6250,
    parameter int unsigned WIN_DIST_RO  = 800,
    parameter int unsigned WIN_BURST    = 820000,
    parameter int unsigned RO_EXIT_RSV  = 410000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strat_i,
    input  logic       sleep_req,
    input  logic       wake_req,
    input  logic       ref_tick,
    input  logic       burst_start,
    output logic       ras_n,
    output logic       cas_n,
    output logic       busy,
    output logic       asleep,
    output logic       ref_req
);
    localparam int unsigned AGE_MAX = WIN_BURST + T_CSR + 1;
    localparam int unsigned AGE_W   = $clog2(AGE_MAX + 1);
    localparam int unsigned PH_MAX  = srx_max(srx_max(srx_max(T_CSR, T_CRAS), srx_max(T_RP, T_RASS)),
                                              srx_max(T_CHS, T_RPS));
    localparam int unsigned PH_W    = $clog2(PH_MAX + 1);

    srx_state_e       state_q, state_n;
    logic [PH_W-1:0]  ph_len;
    logic             ph_done;
    logic             ph_restart;
    logic [AGE_W-1:0] age;
    logic [AGE_W-1:0] lim;
    logic             mark;
    logic             catch_clr;
    logic             entry_fits;

    srx_win #(
        .WIN_DIST_CBR (WIN_DIST_CBR),
        .WIN_DIST_RO  (WIN_DIST_RO),
        .WIN_BURST    (WIN_BURST),
        .RO_EXIT_RSV  (RO_EXIT_RSV),
        .LIM_W        (AGE_W)
    ) u_win (
        .strat       (strat_i),
        .ref_tick    (ref_tick),
        .burst_start (burst_start),
        .lim         (lim),
        .mark        (mark)
    );

    // The catch-up RAS fall counts as a fresh refresh marker.
    assign catch_clr = (state_q == ST_CATCH_CAS) && ph_done;

    srx_age #(
        .AGE_MAX (AGE_MAX),
        .AGE_W   (AGE_W)
    ) u_age (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mark | catch_clr),
        .age   (age)
    );

    assign ph_restart = (state_n != state_q);

    srx_phase #(
        .PH_W (PH_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ph_restart),
        .len     (ph_len),
        .done    (ph_done)
    );

    // A direct entry puts the RAS fall T_CSR + 1 edges after this cycle's age.
    assign entry_fits = (32'(age) + 32'(T_CSR) + 32'd1) <= 32'(lim);

    always_comb begin
        ph_len = '0;
        unique case (state_q)
            ST_CATCH_CAS: ph_len = PH_W'(T_CSR);
            ST_CATCH_RAS: ph_len = PH_W'(T_CRAS);
            ST_CATCH_PRE: ph_len = PH_W'(T_RP);
            ST_ENTER_CAS: ph_len = PH_W'(T_CSR);
            ST_SR_MIN:    ph_len = PH_W'(T_RASS);
            ST_EXIT_RAS:  ph_len = PH_W'(T_CHS);
            ST_EXIT_PRE:  ph_len = PH_W'(T_RPS);
            default:      ph_len = '0;
        endcase
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:      if (sleep_req) state_n = entry_fits ? ST_ENTER_CAS : ST_CATCH_CAS;
            ST_CATCH_CAS: if (ph_done)   state_n = ST_CATCH_RAS;
            ST_CATCH_RAS: if (ph_done)   state_n = ST_CATCH_PRE;
            ST_CATCH_PRE: if (ph_done)   state_n = ST_ENTER_CAS;
            ST_ENTER_CAS: if (ph_done)   state_n = ST_SR_MIN;
            ST_SR_MIN:    if (ph_done)   state_n = ST_SR_HOLD;
            ST_SR_HOLD:   if (wake_req)  state_n = ST_EXIT_RAS;
            ST_EXIT_RAS:  if (ph_done)   state_n = ST_EXIT_PRE;
            ST_EXIT_PRE:  if (ph_done)   state_n = ST_IDLE;
            default:                     state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_req <= 1'b0;
        end else if ((state_q == ST_EXIT_PRE) && ph_done) begin
            ref_req <= 1'b1;
        end else if (ref_tick) begin
            ref_req <= 1'b0;
        end
    end

    always_comb begin
        ras_n  = 1'b1;
        cas_n  = 1'b1;
        busy   = 1'b1;
        asleep = 1'b0;
        unique case (state_q)
            ST_IDLE:      busy = 1'b0;
            ST_CATCH_CAS: cas_n = 1'b0;
            ST_CATCH_RAS: begin ras_n = 1'b0; cas_n = 1'b0; end
            ST_CATCH_PRE: ;
            ST_ENTER_CAS: cas_n = 1'b0;
            ST_SR_MIN:    begin ras_n = 1'b0; cas_n = 1'b0; asleep = 1'b1; end
            ST_SR_HOLD:   begin ras_n = 1'b0; cas_n = 1'b0; asleep = 1'b1; busy = 1'b0; end
            ST_EXIT_RAS:  cas_n = 1'b0;
            ST_EXIT_PRE:  ;
            default:      ;
        endcase
    end

    // Sleep length counter, kept only for the checks below.
    logic [PH_W-1:0] slp_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slp_cnt <= '0;
        end else if (asleep) begin
            if (slp_cnt != PH_W'(T_RASS)) slp_cnt <= slp_cnt + PH_W'(1);
        end else begin
            slp_cnt <= '0;
        end
    end

    // R2
    cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    // R2
    no_ras_without_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R3
    min_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> ($past(slp_cnt) >= PH_W'(T_RASS)));

    // R7
    exit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> (ras_n && !cas_n));

    // R4
    entry_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ENTER_CAS) && ph_done) |-> ((32'(age) + 32'd1) <= 32'(lim)));

    // R8
    ref_req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_req) |-> ($past(state_q) == ST_EXIT_PRE));
endmodule

// File: tb/srx_seq_bench.sv
module srx_seq_bench;
    localparam int T_CSR  = 2;
    localparam int T_CRAS = 4;
    localparam int T_RP   = 3;
    localparam int T_RASS = 20;
    localparam int T_CHS  = 2;
    localparam int T_RPS  = 5;
    localparam int W_DC   = 40;
    localparam int W_DR   = 15;
    localparam int W_B    = 90;
    localparam int W_RSV  = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strat = 2'b00;
    logic       sleep_req = 1'b0;
    logic       wake_req = 1'b0;
    logic       ref_tick = 1'b0;
    logic       burst_start = 1'b0;
    logic       ras_n, cas_n, busy, asleep, ref_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    srx_seq #(
        .T_CSR (T_CSR), .T_CRAS (T_CRAS), .T_RP (T_RP), .T_RASS (T_RASS),
        .T_CHS (T_CHS), .T_RPS (T_RPS), .WIN_DIST_CBR (W_DC), .WIN_DIST_RO (W_DR),
        .WIN_BURST (W_B), .RO_EXIT_RSV (W_RSV)
    ) u_srx_seq (
        .clk (clk), .rst_n (rst_n), .strat_i (strat), .sleep_req (sleep_req),
        .wake_req (wake_req), .ref_tick (ref_tick), .burst_start (burst_start),
        .ras_n (ras_n), .cas_n (cas_n), .busy (busy), .asleep (asleep), .ref_req (ref_req)
    );

    typedef struct {
        logic  ras;
        logic  cas;
        logic  bsy;
        logic  slp;
        string tag;
    } exp_t;

    exp_t   q[$];
    exp_t   cur;
    int     mode;
    longint n = 0;
    longint last_mark;
    longint cm;
    logic   exp_ref;

    function automatic exp_t mk(logic r, logic c, logic b, logic s, string t);
        exp_t e;
        e.ras = r; e.cas = c; e.bsy = b; e.slp = s; e.tag = t;
        return e;
    endfunction

    function automatic void pushn(int k, exp_t e);
        for (int i = 0; i < k; i++) q.push_back(e);
    endfunction

    function automatic longint lim_of(logic [1:0] s);
        case (s)
            2'b00:   return W_DC;
            2'b01:   return W_DR;
            2'b10:   return W_B;
            default: return W_B - W_RSV;
        endcase
    endfunction

    // Behavioural reference: expected strobes per cycle, queued per sequence.
    always @(posedge clk) begin
        n++;
        if (!rst_n) begin
            q.delete();
            cur = mk(1, 1, 0, 0, "R1");
            mode = 0;
            exp_ref = 0;
            last_mark = -1000000;
        end else begin
            cm = -1;
            if (mode == 0 && sleep_req) begin
                if ((n - 1 - last_mark) + 1 + T_CSR > lim_of(strat)) begin
                    pushn(T_CSR,  mk(1, 0, 1, 0, "R5"));
                    pushn(T_CRAS, mk(0, 0, 1, 0, "R5"));
                    pushn(T_RP,   mk(1, 1, 1, 0, "R5"));
                    cm = n + T_CSR;
                end
                pushn(T_CSR,  mk(1, 0, 1, 0, "R2"));
                pushn(T_RASS, mk(0, 0, 1, 1, "R3"));
                mode = 1;
            end else if (mode == 2 && wake_req) begin
                pushn(T_CHS, mk(1, 0, 1, 0, "R7"));
                pushn(T_RPS, mk(1, 1, 1, 0, "R7"));
                mode = 3;
            end
            if ((strat[1] ? burst_start : ref_tick) && n > last_mark) last_mark = n;
            if (cm >= 0) last_mark = cm;
            if (ref_tick) exp_ref = 0;
            if (q.size() > 0) begin
                cur = q.pop_front();
            end else if (mode == 1) begin
                cur = mk(0, 0, 0, 1, "R9");
                mode = 2;
            end else if (mode == 3) begin
                cur = mk(1, 1, 0, 0, "R8");
                mode = 0;
                exp_ref = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && n > 0) begin
            checks++;
            if ({ras_n, cas_n, busy, asleep, ref_req} !== {cur.ras, cur.cas, cur.bsy, cur.slp, exp_ref}) begin
                errors++;
                $display("FAIL %s cycle %0d: actual ras,cas,busy,asleep,ref=%b expected %b",
                         cur.tag, n, {ras_n, cas_n, busy, asleep, ref_req},
                         {cur.ras, cur.cas, cur.bsy, cur.slp, exp_ref});
            end
        end
    end

    task automatic chk(string tag, longint act, longint exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
    endtask

    task automatic pulse_burst();
        @(negedge clk); burst_start = 1'b1;
        @(negedge clk); burst_start = 1'b0;
    endtask

    task automatic go_sleep(bit exp_catch, string tag);
        bit     saw;
        longint fall;
        saw = 1'b0;
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk);
        chk("R2", {ras_n, cas_n}, 2'b10, "CAS low before RAS");
        while (!asleep) begin
            if (!ras_n) saw = 1'b1;
            @(negedge clk);
        end
        sleep_req = 1'b0;
        fall = n;
        chk(tag, saw, exp_catch, "catch-up refresh issued");
        chk("R4", (fall - last_mark <= lim_of(strat)) ? 1 : 0, 1, "RAS fall within window");
    endtask

    task automatic go_wake();
        repeat (T_RASS + 2) @(negedge clk);
        chk("R9", {busy, asleep}, 2'b01, "held sleep status");
        wake_req = 1'b1;
        @(negedge clk);
        chk("R7", {ras_n, cas_n}, 2'b10, "RAS rises before CAS");
        while (busy) @(negedge clk);
        wake_req = 1'b0;
        chk("R8", ref_req, 1, "refresh request after exit");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {ras_n, cas_n, busy, asleep, ref_req}, 5'b11000, "outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {ras_n, cas_n, busy, asleep, ref_req}, 5'b11000, "outputs after reset");

        // Stale age after reset, early wake held off, refresh request handshake.
        strat = 2'b00;
        go_sleep(1, "R10");
        wake_req = 1'b1;
        repeat (5) @(negedge clk);
        chk("R3", {ras_n, asleep}, 2'b01, "early wake ignored");
        while (busy || asleep) @(negedge clk);
        wake_req = 1'b0;
        chk("R8", ref_req, 1, "refresh request raised");
        repeat (3) @(negedge clk);
        chk("R8", ref_req, 1, "refresh request held");
        pulse_tick();
        chk("R8", ref_req, 0, "refresh request cleared by tick");

        // Distributed CBR, fresh marker: direct entry.
        idle_wait(5);
        go_sleep(0, "R4");
        go_wake();

        // Distributed RAS-only, too old: catch-up.
        strat = 2'b01;
        pulse_tick();
        idle_wait(20);
        go_sleep(1, "R5");
        go_wake();

        // Distributed RAS-only, fresh: direct.
        pulse_tick();
        idle_wait(3);
        go_sleep(0, "R4");
        go_wake();

        // Burst CBR, inside the wide window: direct.
        strat = 2'b10;
        pulse_burst();
        idle_wait(50);
        go_sleep(0, "R4");
        go_wake();

        // Burst CBR: a late ref_tick must not refresh the age.
        pulse_burst();
        idle_wait(100);
        pulse_tick();
        go_sleep(1, "R6");
        go_wake();

        // Burst RAS-only, reduced window: inside then outside.
        strat = 2'b11;
        pulse_burst();
        idle_wait(20);
        go_sleep(0, "R4");
        go_wake();
        pulse_burst();
        idle_wait(32);
        go_sleep(1, "R5");
        go_wake();

        // Distributed CBR: a burst_start must not refresh the age.
        strat = 2'b00;
        pulse_tick();
        idle_wait(45);
        pulse_burst();
        go_sleep(1, "R6");
        go_wake();

        idle_wait(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic idle_wait(int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog expired: actual cycles %0d expected below %0d", 20000, 20000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule